// File: doc/BRIEF.md
# I/O Space Wait-State Generator

This block sits between a processor core and a small memory-mapped peripheral I/O space of 2048 sixteen-bit locations. The core presents a request made of an 11-bit I/O address, a read/write flag and write data; the block then drives the external bus. It puts out the address, an I/O select, a read or write strobe and the write data. It holds them for a number of clock cycles set by the address region, and it signals completion to the core with a one-cycle done pulse.

The I/O space is split into four fixed regions of 512 locations each, and each region has its own 3-bit wait count. The hardware inserts the wait cycles on its own. The peripheral never answers with a handshake, so a slow device only needs a larger count for its region. All counts come out of reset at their maximum of 7, which keeps slow devices safe before software programs them. A request made while an access is running is held off by `req_ready` until that access finishes.

Top module: `io_wait_gen`

## Requirements
- R1: After reset, all four wait counts are 7, `req_ready` is 1, `io_sel`, `io_rd`, `io_wr` and `done` are 0, and `rdata` is 0.
- R2: During an access, `io_addr[10:0]` equals the accepted request address and `io_addr[13:11]` is 0. The address stays constant for the whole access.
- R3: A write asserts `io_wr` with `io_wdata` equal to the accepted write data, and a read asserts `io_rd`. `io_rd` and `io_wr` are never both high, and `io_wdata` is 0 whenever no write strobe is active.
- R4: An access accepted at a clock edge with wait count N holds `io_sel` high for exactly N+1 consecutive cycles, starting in the cycle after acceptance. `done` is high only in the last of those cycles.
- R5: Address bits [10:9] pick the wait count: 0 for 0x000–0x1FF, 1 for 0x200–0x3FF, 2 for 0x400–0x5FF and 3 for 0x600–0x7FF.
- R6: When `cfg_we` is high at a clock edge, wait count `cfg_sel` takes the value `cfg_val`. The new value applies to accesses accepted after that edge. An access already running keeps the length it started with.
- R7: At the clock edge that ends a read, `io_rdata` is captured. `rdata` shows the captured value from the next cycle on and holds it until another read completes. Writes leave it unchanged.
- R8: `req_ready` is low in every cycle where `io_sel` is high and high otherwise. A request held while `req_ready` is low does not start an access, so `io_sel` is 0 in the cycle after `done` whenever the request has been withdrawn by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core requests an I/O access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | I/O word address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Block can accept a request this cycle |
| done | output | 1 | Pulses in the final cycle of an access |
| rdata | output | 16 | Last captured read data |
| cfg_we | input | 1 | Write enable for a wait count |
| cfg_sel | input | 2 | Region whose wait count is written |
| cfg_val | input | 3 | New wait count |
| io_addr | output | 14 | External address bus |
| io_sel | output | 1 | I/O space select, active high |
| io_rd | output | 1 | Read strobe, active high |
| io_wr | output | 1 | Write strobe, active high |
| io_wdata | output | 16 | External write data |
| io_rdata | input | 16 | External read data |

## Verification
The assertions assume the core follows the handshake. It keeps `req_valid` and the request fields steady until the edge at which `req_ready` is sampled high. The peripheral drives `io_rdata` from the current address with no delay of its own. The bench raises requests only between accesses and withdraws them one edge after acceptance. The one exception is a deliberate stray request, which is raised mid-access and dropped no later than the `done` cycle. Configuration writes in the middle of an access are made only when the running count is at least 2, so they never land on the acceptance edge.

// File: rtl/io_wait_pkg.sv
package io_wait_pkg;
    localparam int unsigned IO_AW      = 11;
    localparam int unsigned IO_DW      = 16;
    localparam int unsigned IO_EXT_AW  = 14;
    localparam int unsigned WAIT_W     = 3;
    localparam int unsigned N_REGIONS  = 4;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_e;
endpackage

// File: rtl/io_region_decode.sv
module io_region_decode #(
    parameter int unsigned AW = 11,
    parameter int unsigned RW = 2
) (
    input  logic [AW-1:0] addr,
    output logic [RW-1:0] region
);
    // Regions are equal slices of the space, picked by the top address bits.
    always_comb begin
        region = addr[AW-1 -: RW];
    end
endmodule

// File: rtl/io_wait_bank.sv
module io_wait_bank #(
    parameter int unsigned REGIONS = 4,
    parameter int unsigned WW      = 3,
    localparam int unsigned RW     = $clog2(REGIONS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [RW-1:0]                 cfg_sel,
    input  logic [WW-1:0]                 cfg_val,
    output logic [REGIONS-1:0][WW-1:0]    waits
);
    for (genvar g = 0; g < REGIONS; g++) begin : g_reg
        logic [WW-1:0] w_d, w_q;

        always_comb begin
            w_d = w_q;
            if (cfg_we && (cfg_sel == RW'(g))) begin
                w_d = cfg_val;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                w_q <= '1;
            end else begin
                w_q <= w_d;
            end
        end

        assign waits[g] = w_q;
    end

    // R6: a configuration write lands in the selected register.
    assert_cfg_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (waits[$past(cfg_sel)] == $past(cfg_val)));
endmodule

// File: rtl/io_wait_gen.sv
module io_wait_gen
    import io_wait_pkg::*;
#(
    parameter int unsigned AW      = IO_AW,
    parameter int unsigned DW      = IO_DW,
    parameter int unsigned EXT_AW  = IO_EXT_AW,
    parameter int unsigned WW      = WAIT_W,
    parameter int unsigned REGIONS = N_REGIONS,
    localparam int unsigned RW     = $clog2(REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DW-1:0]     rdata,
    input  logic              cfg_we,
    input  logic [RW-1:0]     cfg_sel,
    input  logic [WW-1:0]     cfg_val,
    output logic [EXT_AW-1:0] io_addr,
    output logic              io_sel,
    output logic              io_rd,
    output logic              io_wr,
    output logic [DW-1:0]     io_wdata,
    input  logic [DW-1:0]     io_rdata
);
    typedef struct packed {
        logic          active;
        acc_kind_e     kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [WW-1:0] cnt;
        logic [DW-1:0] rdata;
    } acc_state_t;

    acc_state_t st_d, st_q;

    logic [REGIONS-1:0][WW-1:0] waits;
    logic [RW-1:0]              req_region;

    io_region_decode #(.AW(AW), .RW(RW)) u_decode (
        .addr   (req_addr),
        .region (req_region)
    );

    io_wait_bank #(.REGIONS(REGIONS), .WW(WW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_sel (cfg_sel),
        .cfg_val (cfg_val),
        .waits   (waits)
    );

    logic last_cycle;
    assign last_cycle = st_q.active && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (req_valid) begin
                st_d.active = 1'b1;
                st_d.kind   = req_write ? ACC_WRITE : ACC_READ;
                st_d.addr   = req_addr;
                st_d.wdata  = req_wdata;
                st_d.cnt    = waits[req_region];
            end
        end else if (last_cycle) begin
            st_d.active = 1'b0;
            if (st_q.kind == ACC_READ) begin
                st_d.rdata = io_rdata;
            end
        end else begin
            st_d.cnt = st_q.cnt - WW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, kind: ACC_READ, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = !st_q.active;
    assign done      = last_cycle;
    assign rdata     = st_q.rdata;
    assign io_sel    = st_q.active;
    assign io_rd     = st_q.active && (st_q.kind == ACC_READ);
    assign io_wr     = st_q.active && (st_q.kind == ACC_WRITE);
    assign io_wdata  = io_wr ? st_q.wdata : '0;
    assign io_addr   = {{(EXT_AW-AW){1'b0}}, st_q.addr};

    // Independent length tracking for the access-length assertion.
    logic [WW:0]   len_q;
    logic [WW-1:0] lat_wait_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q      <= '0;
            lat_wait_q <= '0;
        end else begin
            len_q <= (io_sel && !done) ? len_q + 1'b1 : '0;
            if (req_valid && req_ready) begin
                lat_wait_q <= waits[req_addr[AW-1 -: RW]];
            end
        end
    end

    assert_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (len_q == {1'b0, lat_wait_q}));
    assert_done_in_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> io_sel);
    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> (io_rd != io_wr));
    assert_no_wdata_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |-> (io_wdata == '0));
    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && !done) |=> (io_sel && $stable(io_addr)));
    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> !req_ready);
    assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && io_rd) |=> $stable(rdata));
endmodule

// File: tb/io_wait_gen_tb_top.sv
module io_wait_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [10:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, done;
    logic [15:0] rdata;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [2:0]  cfg_val = '0;
    logic [13:0] io_addr;
    logic        io_sel, io_rd, io_wr;
    logic [15:0] io_wdata, io_rdata;

    int checks = 0;
    int fails  = 0;
    int exp_wait [4];
    logic [15:0] exp_rdata = '0;

    always #4 clk = ~clk;

    function automatic logic [15:0] periph(input logic [10:0] a);
        return {a[4:0], a} ^ 16'h5A3C;
    endfunction

    assign io_rdata = periph(io_addr[10:0]);

    io_wait_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rdata(rdata), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_val(cfg_val), .io_addr(io_addr), .io_sel(io_sel), .io_rd(io_rd),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [2:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_val = val;
        @(negedge clk);
        cfg_we = 1'b0;
        exp_wait[sel] = val;
    endtask

    // One access; optional mid-access config write and stray request.
    task automatic access(input logic [10:0] a, input bit wr, input logic [15:0] wd,
                          input bit mid_cfg, input logic [1:0] msel,
                          input logic [2:0] mval, input bit stray);
        int n_exp;
        int len;
        bool_loop: begin end
        @(negedge clk);
        check(req_ready === 1'b1, "R8", "ready before access", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        n_exp = exp_wait[a[10:9]];
        @(negedge clk);
        if (stray) begin
            req_addr = a ^ 11'h155; req_write = ~wr;
        end else begin
            req_valid = 1'b0;
        end
        len = 0;
        while (1) begin
            len++;
            if (len == 1) begin
                check(io_addr === {3'b000, a}, "R2", "address", io_addr, {3'b000, a});
                check(io_rd === !wr && io_wr === wr, "R3", "strobe", {io_rd, io_wr},
                      {!wr, wr});
                if (wr) check(io_wdata === wd, "R3", "write data", io_wdata, wd);
                else check(io_wdata === 16'h0, "R3", "wdata idle on read", io_wdata, 0);
                check(req_ready === 1'b0, "R8", "ready during access", req_ready, 0);
            end
            check(io_sel === 1'b1, "R4", "select held", io_sel, 1);
            if (mid_cfg && len == 1) begin
                cfg_we = 1'b1; cfg_sel = msel; cfg_val = mval;
            end
            if (mid_cfg && len == 2) begin
                cfg_we = 1'b0;
                exp_wait[msel] = mval;
            end
            if (done === 1'b1 || len > 20) break;
            @(negedge clk);
        end
        check(len == n_exp + 1, "R4", "access length", len, n_exp + 1);
        check(io_addr === {3'b000, a}, "R2", "address at end", io_addr, {3'b000, a});
        req_valid = 1'b0;
        if (!wr) exp_rdata = periph(a);
        @(negedge clk);
        check(io_sel === 1'b0, "R8", "no access from held request", io_sel, 0);
        check(rdata === exp_rdata, "R7", "read data", rdata, exp_rdata);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (250000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 4; i++) exp_wait[i] = 7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready === 1'b1, "R1", "ready", req_ready, 1);
        check({io_sel, io_rd, io_wr, done} === 4'b0, "R1", "bus idle",
              {io_sel, io_rd, io_wr, done}, 0);
        check(rdata === 16'h0, "R1", "rdata", rdata, 0);
        // R1/R5: reset count 7 in every region
        for (int r = 0; r < 4; r++) access(11'(r * 512 + 3), 1'b0, '0, 0, '0, '0, 0);
        // R5: region boundaries with distinct counts
        cfg_write(2'd0, 3'd0); cfg_write(2'd1, 3'd1);
        cfg_write(2'd2, 3'd4); cfg_write(2'd3, 3'd2);
        access(11'h1FF, 1'b0, '0, 0, '0, '0, 0);
        access(11'h200, 1'b1, 16'hBEEF, 0, '0, '0, 0);
        access(11'h3FF, 1'b0, '0, 0, '0, '0, 0);
        access(11'h400, 1'b1, 16'h1234, 0, '0, '0, 0);
        access(11'h5FF, 1'b0, '0, 0, '0, '0, 0);
        access(11'h600, 1'b0, '0, 0, '0, '0, 0);
        access(11'h7FF, 1'b1, 16'hFFFF, 0, '0, '0, 0);
        access(11'h000, 1'b1, 16'h0001, 0, '0, '0, 0);
        // R6: change region 2 mid-access; running access keeps 4
        access(11'h4AA, 1'b0, '0, 1, 2'd2, 3'd6, 0);
        access(11'h4AB, 1'b0, '0, 0, '0, '0, 0);
        // R8: stray request held during busy
        access(11'h123, 1'b0, '0, 0, '0, '0, 1);
        access(11'h623, 1'b1, 16'hA5A5, 0, '0, '0, 1);
        // R7: write leaves rdata untouched (checked inside access)
        access(11'h0F0, 1'b1, 16'h7777, 0, '0, '0, 0);
        // Random mix
        for (int k = 0; k < 200; k++) begin
            if ($urandom_range(0, 3) == 0)
                cfg_write(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)));
            access(11'($urandom), 1'($urandom), 16'($urandom), 0, '0, '0,
                   ($urandom_range(0, 7) == 0));
        end
        summary();
    end
endmodule